// File: doc/BRIEF.md
# Sequential Line Prefetch Accelerator for Flash Code Fetch

This block sits between a 32-bit instruction-fetch port and a slow flash array that reads 128 bits at a time. It keeps two 16-byte line buffers. A processor read that lands in a buffered line is answered in the cycle it is presented. While the processor is still consuming words from one line, the block fetches the following line (line address plus one, which is byte address plus 16) into the other buffer. The two buffers swap roles as the run advances, so a straight run of code pays the array latency only on its first word.

The array latency is programmed as a wait-state count from 0 to 3. An array access holds the array strobe and line address for wait+1 cycles, and the data is captured at the end of the last one. A bypass bit turns the buffers off: every read then goes to the array on its own and nothing is prefetched. Any change to the bypass bit or the wait-state count empties both buffers and abandons any array access in flight. A read that misses both buffers abandons a prefetch that is in flight and starts its own access at once. A read for the line that a prefetch is already fetching waits for that prefetch to finish.

Top module: `fetch_line_accel`

## Requirements
- R1: After reset, with no request, `cpu_ready` and `mem_req` are 0 and both buffers are empty, so the first read takes wait+1 cycles.
- R2: A line is 16 bytes on a 16-byte boundary. `cpu_word_addr[3:2]` selects word i of the line, which is taken from `mem_rdata[32*i+31:32*i]`. `mem_addr` is the byte address shifted right by 4.
- R3: With the wait-state count at 0, every request, whether hit or miss, is answered with `cpu_ready` high in the cycle it is presented.
- R4: A read that misses both buffers takes wait+1 cycles, counting the request cycle as the first, and its data is forwarded straight from the array.
- R5: After the first read of a sequential run of 32-bit reads, each following read in the run is answered in 1 cycle, for wait-state counts 0 to 3.
- R6: A hit on line L starts a fetch of line L+1 in that same cycle (`mem_req`=1, `mem_addr`=L+1) if L+1 is neither buffered nor already in flight. A read for a line whose fetch is in flight waits until that fetch completes.
- R7: A fetched line stays valid until it is replaced. After idle cycles, a read of it or of the line prefetched before the gap takes 1 cycle.
- R8: A miss abandons any prefetch in flight and starts a new array access for the missed line in the same cycle.
- R9: With bypass set to 1, every read, sequential or not, takes wait+1 cycles and its data comes from the array.
- R10: A change of the bypass bit or the wait-state count invalidates both buffers, so the next read of a line that was buffered takes wait+1 cycles.
- R11: An array access drives `mem_req`=1 with a stable `mem_addr` from its first cycle, for exactly wait+1 cycles.
- R12: The two buffers never hold the same line while both are valid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cfg_bypass | input | 1 | 1 = buffers off, every read goes to the array |
| cfg_wait | input | 2 | Wait states; an array access lasts cfg_wait+1 cycles |
| cpu_req | input | 1 | Read request, held until cpu_ready |
| cpu_word_addr | input | AW-2 | Word address of the read (byte address bits AW-1:2) |
| cpu_ready | output | 1 | Read completes at the next rising edge |
| cpu_rdata | output | 32 | Read data, valid while cpu_ready is 1 |
| mem_req | output | 1 | Array strobe, high for the whole access |
| mem_addr | output | AW-4 | Line address presented to the array |
| mem_rdata | input | 128 | Array line data for mem_addr |

## Verification
The hardest case to reach is a read that arrives while a prefetch is partly done. It must either wait for the fetch in flight, when it asks for that very line, or cut the fetch short, when it asks for another line. That depends on the exact cycle the request appears relative to the hidden prefetch counter. The bench reaches both cases with back-to-back reads at three wait states. A hit on word 1 of a fresh line starts the prefetch, and the next request follows one cycle later, either for the next line (expect three cycles) or for a distant line in the cycle the prefetch would have finished (expect the full four-cycle miss). Buffers that stay valid across idle gaps are checked by putting idle cycles between reads and expecting single-cycle answers.

// File: rtl/fla_pkg.sv
package fla_pkg;
  localparam int WORD_W   = 32;
  localparam int LINE_W   = 128;
  localparam int WPL      = LINE_W / WORD_W;
  localparam int SEL_W    = $clog2(WPL);
  localparam int OFF_W    = SEL_W + 2;
  localparam int NBUF     = 2;
  localparam int WAIT_W   = 2;

  typedef logic [WORD_W-1:0] word_t;
  typedef logic [LINE_W-1:0] line_t;
  typedef logic [SEL_W-1:0]  sel_t;
  typedef logic [WAIT_W-1:0] wait_t;
endpackage

// File: rtl/fla_line_buf.sv
module fla_line_buf
  import fla_pkg::*;
#(
  parameter int TAG_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             flush,
  input  logic             wr_en,
  input  logic [TAG_W-1:0] wr_tag,
  input  line_t            wr_data,
  input  sel_t             rd_sel,
  output logic             valid_o,
  output logic [TAG_W-1:0] tag_o,
  output word_t            word_o
);
  logic             valid_q, valid_d;
  logic [TAG_W-1:0] tag_q;
  line_t            data_q;

  always_comb begin
    valid_d = valid_q;
    if (flush) valid_d = 1'b0;
    if (wr_en) valid_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) valid_q <= 1'b0;
    else        valid_q <= valid_d;
  end

  always_ff @(posedge clk) begin
    if (wr_en) begin
      tag_q  <= wr_tag;
      data_q <= wr_data;
    end
  end

  assign valid_o = valid_q;
  assign tag_o   = tag_q;
  assign word_o  = data_q[rd_sel*WORD_W +: WORD_W];

  // R7: a filled line is valid on the following cycle
  assert_fill_valid_R7: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> valid_q);
endmodule

// File: rtl/fla_array_seq.sv
module fla_array_seq
  import fla_pkg::*;
#(
  parameter int TAG_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             kill,
  input  wait_t            wait_cfg,
  input  logic             start,
  input  logic [TAG_W-1:0] start_line,
  input  logic             start_tgt,
  input  logic             start_cap,
  output logic             pend_o,
  output logic [TAG_W-1:0] pend_line_o,
  output logic             act_o,
  output logic [TAG_W-1:0] line_o,
  output logic             tgt_o,
  output logic             cap_o,
  output logic             done_o
);
  logic             busy_q, busy_d;
  wait_t            cnt_q, cnt_d, cnt_cur;
  logic [TAG_W-1:0] line_q;
  logic             tgt_q, cap_q;

  assign pend_o      = busy_q & ~kill;
  assign pend_line_o = line_q;
  assign act_o       = start | pend_o;
  assign line_o      = start ? start_line : line_q;
  assign tgt_o       = start ? start_tgt  : tgt_q;
  assign cap_o       = start ? start_cap  : cap_q;
  assign cnt_cur     = start ? '0 : cnt_q;
  assign done_o      = act_o & (cnt_cur == wait_cfg);

  always_comb begin
    busy_d = act_o & ~done_o;
    cnt_d  = cnt_cur + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
    end else begin
      busy_q <= busy_d;
      if (act_o) cnt_q <= cnt_d;
    end
  end

  always_ff @(posedge clk) begin
    if (act_o) begin
      line_q <= line_o;
      tgt_q  <= tgt_o;
      cap_q  <= cap_o;
    end
  end

  // R11: an access in flight never runs past its wait-state budget
  assert_cnt_in_budget_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && !kill) |-> (cnt_q <= wait_cfg));
endmodule

// File: rtl/fetch_line_accel.sv
module fetch_line_accel
  import fla_pkg::*;
#(
  parameter int AW = 20
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cfg_bypass,
  input  logic [1:0]      cfg_wait,
  input  logic            cpu_req,
  input  logic [AW-1:2]   cpu_word_addr,
  output logic            cpu_ready,
  output logic [31:0]     cpu_rdata,
  output logic            mem_req,
  output logic [AW-5:0]   mem_addr,
  input  logic [127:0]    mem_rdata
);
  localparam int TAG_W = AW - OFF_W;

  logic rst_s1, rst_ni;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_s1 <= 1'b0;
      rst_ni <= 1'b0;
    end else begin
      rst_s1 <= 1'b1;
      rst_ni <= rst_s1;
    end
  end

  logic  bypass_q;
  wait_t wait_q;
  logic  cfg_chg;
  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      bypass_q <= 1'b0;
      wait_q   <= '0;
    end else begin
      bypass_q <= cfg_bypass;
      wait_q   <= cfg_wait;
    end
  end
  assign cfg_chg = (cfg_bypass != bypass_q) | (cfg_wait != wait_q);

  logic [TAG_W-1:0] req_line, next_line;
  sel_t             req_sel;
  assign req_line  = cpu_word_addr[AW-1:OFF_W];
  assign req_sel   = cpu_word_addr[OFF_W-1:2];
  assign next_line = req_line + 1'b1;

  logic             pend, act, done, tgt, cap;
  logic [TAG_W-1:0] pend_line, eng_line;

  logic             b_valid [NBUF];
  logic [TAG_W-1:0] b_tag   [NBUF];
  word_t            b_word  [NBUF];
  logic [NBUF-1:0]  hit_v;

  for (genvar gi = 0; gi < NBUF; gi++) begin : g_buf
    fla_line_buf #(.TAG_W(TAG_W)) i_buf (
      .clk     (clk),
      .rst_n   (rst_ni),
      .flush   (cfg_chg),
      .wr_en   (done & cap & (tgt == gi[0])),
      .wr_tag  (eng_line),
      .wr_data (mem_rdata),
      .rd_sel  (req_sel),
      .valid_o (b_valid[gi]),
      .tag_o   (b_tag[gi]),
      .word_o  (b_word[gi])
    );
    assign hit_v[gi] = ~cfg_bypass & ~cfg_chg & b_valid[gi] & (b_tag[gi] == req_line);
  end

  logic hit, hit_idx, last_b, last_b_d;
  logic start_dem, pf_need, start, start_tgt, start_cap, fwd;
  logic [TAG_W-1:0] start_line;

  always_comb begin
    hit       = |hit_v;
    hit_idx   = hit_v[1];
    start_dem = cpu_req & ~hit & ~(pend & (pend_line == req_line));
    pf_need   = cpu_req & hit & ~pend &
                ~(b_valid[~hit_idx] & (b_tag[~hit_idx] == next_line));
    start      = start_dem | pf_need;
    start_line = start_dem ? req_line : next_line;
    start_tgt  = start_dem ? ~last_b : ~hit_idx;
    start_cap  = start_dem ? ~cfg_bypass : 1'b1;
    fwd        = cpu_req & done & (eng_line == req_line);
    cpu_ready  = cpu_req & (hit | fwd);
    cpu_rdata  = hit ? b_word[hit_idx] : mem_rdata[req_sel*WORD_W +: WORD_W];
    last_b_d   = last_b;
    if (cpu_ready) last_b_d = hit ? hit_idx : tgt;
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) last_b <= 1'b0;
    else         last_b <= last_b_d;
  end

  fla_array_seq #(.TAG_W(TAG_W)) i_seq (
    .clk         (clk),
    .rst_n       (rst_ni),
    .kill        (cfg_chg),
    .wait_cfg    (cfg_wait),
    .start       (start),
    .start_line  (start_line),
    .start_tgt   (start_tgt),
    .start_cap   (start_cap),
    .pend_o      (pend),
    .pend_line_o (pend_line),
    .act_o       (act),
    .line_o      (eng_line),
    .tgt_o       (tgt),
    .cap_o       (cap),
    .done_o      (done)
  );

  assign mem_req  = act;
  assign mem_addr = eng_line;

  // R3: zero wait states answer every request in its own cycle
  assert_zero_wait_single_R3: assert property (@(posedge clk) disable iff (!rst_ni)
    (cpu_req && cfg_wait == 2'd0) |-> cpu_ready);
  // R9: in bypass mode data only ever comes from an array access of that line
  assert_bypass_from_array_R9: assert property (@(posedge clk) disable iff (!rst_ni)
    (cpu_ready && cfg_bypass) |-> (mem_req && mem_addr == req_line));
  // R12: the two buffers never duplicate a line
  assert_distinct_lines_R12: assert property (@(posedge clk) disable iff (!rst_ni)
    (b_valid[0] && b_valid[1]) |-> (b_tag[0] != b_tag[1]));
  // R11: a multi-cycle access keeps its strobe and address the next cycle
  assert_addr_held_R11: assert property (@(posedge clk) disable iff (!rst_ni)
    (act && !done && !cfg_chg && !start_dem) |=> (mem_req && (cfg_chg || start_dem || mem_addr == $past(eng_line))));
endmodule

// File: tb/test_fetch_line_accel.sv
module test_fetch_line_accel;
  localparam int AW = 20;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          cfg_bypass;
  logic [1:0]    cfg_wait;
  logic          cpu_req;
  logic [AW-1:2] cpu_word_addr;
  logic          cpu_ready;
  logic [31:0]   cpu_rdata;
  logic          mem_req;
  logic [AW-5:0] mem_addr;
  logic [127:0]  mem_rdata;

  int n_chk = 0;
  int n_fail = 0;

  always #4 clk = ~clk;

  // behavioural array: word of byte address A reads 0x5A000000 ^ A
  always_comb
    for (int i = 0; i < 4; i++)
      mem_rdata[32*i +: 32] = 32'h5A00_0000 ^ {12'h0, mem_addr, i[1:0], 2'b00};

  fetch_line_accel #(.AW(AW)) i_fetch_line_accel (
    .clk(clk), .rst_n(rst_n), .cfg_bypass(cfg_bypass), .cfg_wait(cfg_wait),
    .cpu_req(cpu_req), .cpu_word_addr(cpu_word_addr), .cpu_ready(cpu_ready),
    .cpu_rdata(cpu_rdata), .mem_req(mem_req), .mem_addr(mem_addr),
    .mem_rdata(mem_rdata)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  int          r_cyc;
  logic [31:0] r_data;
  logic        r_mreq0;
  logic [15:0] r_maddr0;

  // issue one read at a negedge; returns at the next negedge after it completes
  task automatic rd(input logic [19:0] a);
    cpu_req = 1'b1;
    cpu_word_addr = a[19:2];
    #1;
    r_cyc = 1;
    r_mreq0 = mem_req;
    r_maddr0 = mem_addr;
    while (!cpu_ready && r_cyc < 40) begin
      @(negedge clk); #1;
      r_cyc++;
    end
    r_data = cpu_rdata;
    @(negedge clk);
  endtask

  task automatic rd_chk(input logic [19:0] a, input int cyc, input string req);
    rd(a);
    chk(r_cyc == cyc, req, r_cyc, cyc);
    chk(r_data == (32'h5A00_0000 ^ {12'h0, a}), "R2", r_data, 32'h5A00_0000 ^ {12'h0, a});
  endtask

  task automatic idle(input int n);
    cpu_req = 1'b0;
    repeat (n) @(negedge clk);
  endtask

  // {bypass, wait, byte address, expected cycles}
  localparam logic [26:0] VEC [32] = '{
    {1'b0, 2'd3, 20'h00000, 4'd4}, {1'b0, 2'd3, 20'h00004, 4'd1},
    {1'b0, 2'd3, 20'h00008, 4'd1}, {1'b0, 2'd3, 20'h0000C, 4'd1},
    {1'b0, 2'd3, 20'h00010, 4'd1}, {1'b0, 2'd3, 20'h00014, 4'd1},
    {1'b0, 2'd3, 20'h00018, 4'd1}, {1'b0, 2'd3, 20'h0001C, 4'd1},
    {1'b0, 2'd3, 20'h00020, 4'd1}, {1'b0, 2'd3, 20'h00024, 4'd1},
    {1'b0, 2'd3, 20'h00028, 4'd1}, {1'b0, 2'd3, 20'h0002C, 4'd1},
    {1'b0, 2'd3, 20'h00030, 4'd1}, {1'b0, 2'd3, 20'h00034, 4'd1},
    {1'b0, 2'd3, 20'h00038, 4'd1}, {1'b0, 2'd3, 20'h0003C, 4'd1},
    {1'b0, 2'd3, 20'h00100, 4'd4}, {1'b0, 2'd3, 20'h00030, 4'd1},
    {1'b0, 2'd1, 20'h00200, 4'd2}, {1'b0, 2'd1, 20'h00204, 4'd1},
    {1'b0, 2'd1, 20'h00208, 4'd1}, {1'b0, 2'd1, 20'h0020C, 4'd1},
    {1'b0, 2'd1, 20'h00210, 4'd1}, {1'b0, 2'd0, 20'h00300, 4'd1},
    {1'b0, 2'd0, 20'h00304, 4'd1}, {1'b0, 2'd0, 20'h00310, 4'd1},
    {1'b0, 2'd0, 20'h00500, 4'd1}, {1'b1, 2'd2, 20'h00400, 4'd3},
    {1'b1, 2'd2, 20'h00404, 4'd3}, {1'b1, 2'd2, 20'h00408, 4'd3},
    {1'b0, 2'd2, 20'h00404, 4'd3}, {1'b0, 2'd2, 20'h00408, 4'd1}
  };

  initial begin
    #(8 * 200000);
    n_fail++;
    n_chk++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    cfg_bypass = 1'b0;
    cfg_wait = 2'd0;
    cpu_req = 1'b0;
    cpu_word_addr = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    #1;
    chk(!cpu_ready && !mem_req, "R1", {cpu_ready, mem_req}, 0);
    @(negedge clk);

    // table: R4 misses, R5 runs, R8 abandoned prefetch, R3, R9, R10
    foreach (VEC[k]) begin
      cfg_bypass = VEC[k][26];
      cfg_wait   = VEC[k][25:24];
      rd_chk(VEC[k][23:4], int'(VEC[k][3:0]),
             VEC[k][26] ? "R9" : (VEC[k][25:24] == 2'd0 ? "R3" :
             (VEC[k][3:0] == 4'd1 ? "R5" : "R4")));
    end

    // R11 / R6 / R7: strobe, next-line prefetch, persistence over idle
    idle(2);
    cfg_bypass = 1'b0;
    cfg_wait = 2'd3;
    idle(2);
    rd_chk(20'h00700, 4, "R11");
    chk(r_mreq0 && r_maddr0 == 16'h0070, "R11", r_maddr0, 16'h0070);
    rd_chk(20'h00704, 1, "R5");
    chk(r_mreq0 && r_maddr0 == 16'h0071, "R6", r_maddr0, 16'h0071);
    idle(6);
    rd_chk(20'h00708, 1, "R7");
    rd_chk(20'h00714, 1, "R7");
    // R6: request for the line in flight waits for it
    rd_chk(20'h00800, 4, "R4");
    rd_chk(20'h00804, 1, "R5");
    rd_chk(20'h00810, 3, "R6");
    // R8: distant miss abandons a prefetch that is about to finish
    rd_chk(20'h00900, 4, "R4");
    rd_chk(20'h00904, 1, "R5");
    idle(2);
    rd_chk(20'h00A00, 4, "R8");
    chk(r_maddr0 == 16'h00A0, "R8", r_maddr0, 16'h00A0);

    // R10: wait-state change flushes a buffered line
    idle(1);
    cfg_wait = 2'd2;
    idle(2);
    rd_chk(20'h00A04, 3, "R10");

    // R1: reset mid-run empties the buffers
    idle(1);
    rst_n = 1'b0;
    idle(2);
    rst_n = 1'b1;
    idle(4);
    #1;
    chk(!cpu_ready && !mem_req, "R1", {cpu_ready, mem_req}, 0);
    @(negedge clk);
    rd_chk(20'h00A04, 3, "R1");

    idle(2);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule